// File: doc/BRIEF.md
# Stepped-Frequency Reference Generator

This block is a clocked stimulus source for exercising a phase-locked loop. A single system clock drives it. It produces a square-wave reference that alternates between a fast and a slow frequency. Each frequency is held for a fixed dwell interval, so a loop that follows the reference loses lock at every step and has to reacquire it. A marker output flags every frequency step, so that an instrument can be triggered at the moment of the step and the loop's control voltage can be watched against it. The marker comes as a level that flips at each step and as a one-cycle pulse.

The reference toggles whenever a half-period counter reaches the limit of the active mode. A free-running dwell counter expires every `DWELL` cycles. A four-state machine joins the two counters. `ST_FAST` and `ST_SLOW` are the running states. `ST_FAST_WAIT` and `ST_SLOW_WAIT` hold a dwell expiry that arrived in the middle of a half-period. The machine has these transitions:
- From a running state, expiry together with a half-period boundary moves straight to the other running state (switch).
- From a running state, expiry alone moves to the matching wait state (defer).
- From a wait state, the next boundary moves to the other running state (switch).
- A boundary without expiry keeps the present state (hold).

The default parameters suit a 50 MHz clock. A fast half-period of 2500 cycles gives 10 kHz. A slow half-period of 5000 cycles gives 5 kHz. A dwell of 25,000,000 cycles is half a second.

Top module: `step_ref_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ref_out`, `step_level` and `step_pulse` are 0 and the generator is in the fast mode.
- R2: In the fast mode, every reference half-period lasts exactly `HALF_FAST` cycles. The first rising edge of `ref_out` comes `HALF_FAST` clock edges after reset is released.
- R3: In the slow mode, every reference half-period lasts exactly `HALF_SLOW` cycles.
- R4: The dwell timer expires at clock edges `DWELL`, 2·`DWELL`, 3·`DWELL` and so on, counted from reset release, whatever the mode. Each expiry causes exactly one mode switch. This assumes `DWELL` is greater than both half-periods.
- R5: A mode switch happens on the first edge of `ref_out` at or after a dwell expiry. If the expiry falls on a reference edge, the switch happens on that same edge. So no half-period is ever shorter than the smaller of `HALF_FAST` and `HALF_SLOW`.
- R6: `step_pulse` is high for exactly one cycle on each switch and low at all other times. `step_level` changes only when `step_pulse` is high.
- R7: `step_level` inverts on every switch, on the same clock edge as `step_pulse` rises and as the mode change.
- R8: The modes alternate strictly, starting with fast. The number of `ref_out` toggles from one marker to the next equals the toggles of the mode that was active in between.
- R9: A synchronous reset in the middle of operation returns the outputs to the R1 state. Timing then restarts as if from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_out | output | 1 | Square-wave reference |
| step_level | output | 1 | Marker level, inverted at each frequency step |
| step_pulse | output | 1 | Marker pulse, one cycle at each frequency step |

## Verification
Two events can fall in the same cycle: the dwell expiry and a half-period boundary. When they coincide, the switch must take effect on that edge; when they do not, the expiry must be held over to the next boundary. One instance uses a dwell of 40 cycles, a whole number of both half-periods (5 and 10), so every expiry lands on a reference edge. The other uses 37, so every expiry lands mid-half-period and has to be deferred. For both instances the bench predicts the switch edge from its own count of cycles since reset. It then judges the marker position, every measured half-period, and the toggle count between markers.

// File: rtl/step_ref_pkg.sv
package step_ref_pkg;

    // Running states carry the active mode; wait states hold a deferred expiry.
    typedef enum logic [1:0] {
        ST_FAST      = 2'd0,
        ST_FAST_WAIT = 2'd1,
        ST_SLOW      = 2'd2,
        ST_SLOW_WAIT = 2'd3
    } step_state_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/step_ref_divider.sv
module step_ref_divider #(
    parameter int unsigned HALF_FAST = 2500,
    parameter int unsigned HALF_SLOW = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_sel,
    output logic tick
);
    import step_ref_pkg::*;

    localparam int unsigned MAX_HALF = max_u(max_u(HALF_FAST, HALF_SLOW), 2);
    localparam int unsigned CW       = $clog2(MAX_HALF);
    localparam logic [CW-1:0] LIM_FAST = CW'(HALF_FAST - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(HALF_SLOW - 1);

    logic [CW-1:0] half_cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = slow_sel ? LIM_SLOW : LIM_FAST;
        tick  = (half_cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= '0;
        end else if (tick) begin
            half_cnt <= '0;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/step_ref_dwell.sv
module step_ref_dwell #(
    parameter int unsigned DWELL = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic hit
);
    localparam int unsigned DW      = $clog2((DWELL < 2) ? 2 : DWELL);
    localparam logic [DW-1:0] LAST  = DW'(DWELL - 1);

    logic [DW-1:0] dwell_cnt;

    assign hit = (dwell_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell_cnt <= '0;
        end else if (hit) begin
            dwell_cnt <= '0;
        end else begin
            dwell_cnt <= dwell_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/step_ref_fsm.sv
module step_ref_fsm (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic dwell_hit,
    output logic slow_sel,
    output logic switch_now
);
    import step_ref_pkg::*;

    step_state_t state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FAST;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: switch, defer, hold
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FAST: begin
                if (tick && dwell_hit)  state_nx = ST_SLOW;
                else if (dwell_hit)     state_nx = ST_FAST_WAIT;
            end
            ST_FAST_WAIT: begin
                if (tick)               state_nx = ST_SLOW;
            end
            ST_SLOW: begin
                if (tick && dwell_hit)  state_nx = ST_FAST;
                else if (dwell_hit)     state_nx = ST_SLOW_WAIT;
            end
            ST_SLOW_WAIT: begin
                if (tick)               state_nx = ST_FAST;
            end
        endcase
    end

    // Outputs
    always_comb begin
        slow_sel   = 1'b0;
        switch_now = 1'b0;
        unique case (state)
            ST_FAST: begin
                switch_now = tick && dwell_hit;
            end
            ST_FAST_WAIT: begin
                switch_now = tick;
            end
            ST_SLOW: begin
                slow_sel   = 1'b1;
                switch_now = tick && dwell_hit;
            end
            ST_SLOW_WAIT: begin
                slow_sel   = 1'b1;
                switch_now = tick;
            end
        endcase
    end

endmodule

// File: rtl/step_ref_gen.sv
module step_ref_gen #(
    parameter int unsigned HALF_FAST = 2500,
    parameter int unsigned HALF_SLOW = 5000,
    parameter int unsigned DWELL     = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic ref_out,
    output logic step_level,
    output logic step_pulse
);
    logic tick;
    logic dwell_hit;
    logic slow_sel;
    logic switch_now;
    logic ref_q, level_q, pulse_q;

    step_ref_divider #(
        .HALF_FAST (HALF_FAST),
        .HALF_SLOW (HALF_SLOW)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .slow_sel (slow_sel),
        .tick     (tick)
    );

    step_ref_dwell #(
        .DWELL (DWELL)
    ) u_dwell (
        .clk (clk),
        .rst (rst),
        .hit (dwell_hit)
    );

    step_ref_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .dwell_hit  (dwell_hit),
        .slow_sel   (slow_sel),
        .switch_now (switch_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= 1'b0;
            level_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (tick) begin
                ref_q <= ~ref_q;
            end
            if (switch_now) begin
                level_q <= ~level_q;
            end
            pulse_q <= switch_now;
        end
    end

    assign ref_out    = ref_q;
    assign step_level = level_q;
    assign step_pulse = pulse_q;

endmodule

// File: rtl/step_ref_chk.sv
module step_ref_chk #(
    parameter int unsigned HALF_FAST = 2500,
    parameter int unsigned HALF_SLOW = 5000
) (
    input logic clk,
    input logic rst,
    input logic ref_out,
    input logic step_level,
    input logic step_pulse
);
    localparam int unsigned MIN_HALF = (HALF_FAST < HALF_SLOW) ? HALF_FAST : HALF_SLOW;

    logic [31:0] run_len;
    logic        prev_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len  <= '0;
            prev_ref <= 1'b0;
        end else begin
            prev_ref <= ref_out;
            if (ref_out != prev_ref) begin
                run_len <= 32'd1;
            end else begin
                run_len <= run_len + 32'd1;
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ref_out && !step_level && !step_pulse));

    // R5
    min_half_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_out != prev_ref) |-> (run_len >= MIN_HALF));

    // R5
    pulse_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> (ref_out != $past(ref_out)));

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse);

    // R6
    level_change_chk: assert property (@(posedge clk) disable iff (rst)
        (step_level != $past(step_level)) |-> step_pulse);

    // R7
    level_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> (step_level != $past(step_level)));

endmodule

bind step_ref_gen step_ref_chk #(
    .HALF_FAST (HALF_FAST),
    .HALF_SLOW (HALF_SLOW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_out    (ref_out),
    .step_level (step_level),
    .step_pulse (step_pulse)
);

// File: tb/step_ref_gen_test.sv
module step_ref_gen_test;

    localparam int HF = 5;
    localparam int HS = 10;
    localparam int DW_OFF  = 37;
    localparam int DW_SYNC = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic a_ref, a_lvl, a_pls;
    logic b_ref, b_lvl, b_pls;

    step_ref_gen #(.HALF_FAST(HF), .HALF_SLOW(HS), .DWELL(DW_OFF)) uut (
        .clk(clk), .rst(rst), .ref_out(a_ref), .step_level(a_lvl), .step_pulse(a_pls));

    step_ref_gen #(.HALF_FAST(HF), .HALF_SLOW(HS), .DWELL(DW_SYNC)) uut_sync (
        .clk(clk), .rst(rst), .ref_out(b_ref), .step_level(b_lvl), .step_pulse(b_pls));

    int errors = 0;
    int checks = 0;
    logic sel = 1'b0;
    logic m_ref, m_lvl, m_pls;

    always_comb begin
        m_ref = sel ? b_ref : a_ref;
        m_lvl = sel ? b_lvl : a_lvl;
        m_pls = sel ? b_pls : a_pls;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1: reset state on both instances
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(a_ref == 0 && a_lvl == 0 && a_pls == 0, "R1", "offset outputs in reset",
              {a_ref, a_lvl, a_pls}, 0);
        check(b_ref == 0 && b_lvl == 0 && b_pls == 0, "R1", "sync outputs in reset",
              {b_ref, b_lvl, b_pls}, 0);
        rst = 1'b0;
    endtask

    // Watches one instance from reset release; predicts switches from cycle counts.
    task automatic watch(input logic s, input int ncyc, input int exp_sw,
                         input int e0, input int e1, input int e2, input int e3);
        int dw;
        int cyc;
        int last;
        int next_exp;
        int edges;
        int sw;
        int len;
        int want;
        bit slow;
        bit pend;
        logic pr, pl;
        int elist[4];
        elist = '{e0, e1, e2, e3};
        dw = s ? DW_SYNC : DW_OFF;
        cyc = 0; last = 0; next_exp = dw; edges = 0; sw = 0;
        slow = 0; pend = 0; pr = 1'b0; pl = 1'b0;
        sel = s;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            cyc++;
            if (cyc == next_exp) begin
                pend = 1;
                next_exp += dw;
            end
            if (m_ref != pr) begin
                edges++;
                len  = cyc - last;
                want = slow ? HS : HF;
                check(len == want, slow ? "R3" : "R2", "half-period length", len, want);
                check(m_pls == pend, "R5", "marker on boundary after expiry", m_pls, pend);
                if (pend) begin
                    check(m_lvl != pl, "R7", "marker level inverted", m_lvl, !pl);
                    if (sw < 4)
                        check(edges == elist[sw], "R8", "toggles between markers",
                              edges, elist[sw]);
                    sw++;
                    edges = 0;
                    slow = !slow;
                    pend = 0;
                end
                last = cyc;
            end else if (m_pls || (m_lvl != pl)) begin
                check(0, "R6", "marker away from a switch", {m_pls, m_lvl}, {1'b0, pl});
            end
            pr = m_ref;
            pl = m_lvl;
        end
        check(sw == exp_sw, "R4", "switches per dwell expiry", sw, exp_sw);
    endtask

    // Expiries mid-half-period: switches deferred to edges 40, 80, 115, 155
    task automatic t_deferred();
        do_reset();
        watch(1'b0, 170, 4, 8, 4, 7, 4);
    endtask

    // Expiries coincide with reference edges: switches at 40, 80, 120, 160
    task automatic t_coincident();
        do_reset();
        watch(1'b1, 170, 4, 8, 4, 8, 4);
    endtask

    // R9: reset mid-run restores idle outputs and restarts timing
    task automatic t_mid_reset();
        do_reset();
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(a_ref == 0 && a_lvl == 0 && a_pls == 0, "R9", "outputs after mid-run reset",
              {a_ref, a_lvl, a_pls}, 0);
        check(b_ref == 0 && b_lvl == 0 && b_pls == 0, "R9", "sync outputs after mid-run reset",
              {b_ref, b_lvl, b_pls}, 0);
        @(negedge clk);
        rst = 1'b0;
        watch(1'b0, 45, 1, 8, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_deferred();
        t_coincident();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule